// File: doc/BRIEF.md
# Two-Channel Phase-Alignment Delay

This block removes small timing mismatches between two sampled signal paths, such as the current and voltage channels of an energy meter. Channel A passes through a fixed nominal delay of 44 sample ticks. Channel B passes through an adjustable delay that can be made shorter or longer than that nominal. Channel B can therefore be advanced or delayed relative to channel A. A tick divider produces one sample slot every eight enabled clocks. Samples are accepted only in those slots, and each delay line moves forward by one sample per accepted slot.

The host writes a 6-bit two's-complement calibration code. The code point 0x0D gives no relative shift. Each code step above that point delays channel B by one more tick, and each step below it advances channel B by one tick. The resulting tap is clamped to the depth of the line. Because the outputs are only refreshed on accepted ticks, a new code always applies to whole samples.

Top module: `phase_align_delay`

## Requirements
- R1: `tick_o` is high for exactly one clock in every 8 clocks in which `clk_en` is high, starting with the 8th enabled clock after reset. While `clk_en` is low, the divider holds and `tick_o` stays low.
- R2: On each accepted tick (`tick_o` and `in_valid` both high), `ch_a_out` is loaded with the channel A sample accepted 44 ticks earlier, or with zero if fewer than 44 samples have been accepted since reset.
- R3: On each accepted tick, `ch_b_out` is loaded with the channel B sample accepted T ticks earlier, or with zero if there is no such sample. T = clamp(44 + s − 13, 0, 88), where s is the 6-bit calibration code read as a signed value. When T = 0, the output is the sample accepted on that same tick.
- R4: Code 0x0D gives equal delays on both channels. Code 0x0B makes channel B lead channel A by 2 ticks. Code 0x0F makes channel B lag channel A by 2 ticks.
- R5: Code 0x21 (−31) gives T = 0, and code 0x1F (+31) gives T = 62. Code 0x20 (−32) clamps to T = 0.
- R6: A synchronous active-low reset loads the code 0x0D, clears both delay lines and both outputs to zero, and clears `out_valid`.
- R7: `out_valid` is high for one clock after an accepted tick, and only when at least max(44, T) samples were accepted before that tick. In every other clock it is low.
- R8: A tick with `in_valid` low accepts nothing: the delay lines do not advance and the outputs hold.
- R9: A code write in the same clock as an accepted tick does not affect that tick's outputs. It applies from the next accepted tick on.
- R10: `ch_a_out` and `ch_b_out` change only in the clock that follows an accepted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Clock enable for the tick divider |
| in_valid | input | 1 | Sample strobe, sampled when `tick_o` is high |
| ch_a_in | input | 24 | Channel A sample, signed |
| ch_b_in | input | 24 | Channel B sample, signed |
| cal_we | input | 1 | Calibration code write enable |
| cal_wdata | input | 6 | Calibration code, signed, zero shift at 0x0D |
| tick_o | output | 1 | Sample slot pulse |
| out_valid | output | 1 | Aligned pair valid for one clock |
| ch_a_out | output | 24 | Channel A with the fixed nominal delay |
| ch_b_out | output | 24 | Channel B with the programmed delay |

## Verification
The bench drives offset ramps on both channels, so the difference between the two outputs reads the relative lag directly. It checks that lag at the centre code, two steps either side, and the extremes 0x21, 0x1F and 0x20.

- A clamp that is off by one, or that wraps instead of saturating, gives the wrong lag or wrong data at the extreme codes.
- A code applied mid-slot corrupts the sample of a same-clock write.
- A line that advances on an invalid tick shifts every later expected value by one.
- A fill check tied only to the nominal delay raises `out_valid` early when the tap is longer than 44.
- A wrong reset code shows up as a non-zero lag after a mid-run reset.

// File: rtl/phase_align_pkg.sv
// Shared constants for the two-channel phase-alignment delay.
// Assumes the nominal delay is at least one tick.
package phase_align_pkg;
    localparam int PA_SAMPLE_W = 24;  // sample width in bits
    localparam int PA_CODE_W   = 6;   // calibration code width
    localparam int PA_CENTER   = 13;  // code value that gives zero relative shift
    localparam int PA_NOMINAL  = 44;  // fixed delay of channel A, in ticks
    localparam int PA_TICK_DIV = 8;   // enabled clocks per sample tick
endpackage

// File: rtl/pa_tick_gen.sv
// Sample-slot divider: raises tick for one clock in every DIV enabled clocks.
// Assumes DIV >= 2. The count holds while clk_en is low.
module pa_tick_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    // Count enabled clocks and wrap at the last slot position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clk_en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = clk_en && (cnt == LAST);

    // R1: two ticks are never adjacent.
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R1: a disabled clock leaves the divider untouched.
    p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(cnt));
endmodule

// File: rtl/pa_delay_line.sv
// Tapped sample delay line of DEPTH stages.
// Stage 0 holds the newest accepted sample. A select of 0 returns the input
// directly. A select of k returns the sample accepted k shifts earlier.
// Assumes DEPTH >= 1 and that rd_sel never exceeds DEPTH.
module pa_delay_line #(
    parameter int DW    = 24,
    parameter int DEPTH = 88,
    parameter int SEL_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift,
    input  logic signed [DW-1:0] din,
    input  logic [SEL_W-1:0]     rd_sel,
    output logic signed [DW-1:0] rd_data
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic signed [DW-1:0] stage [DEPTH];
    logic [IDX_W-1:0]     idx;

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_head
            // Load the newest sample into the head stage.
            always_ff @(posedge clk) begin
                if (!rst_n)     stage[0] <= '0;
                else if (shift) stage[0] <= din;
            end
        end else begin : g_body
            // Pass the previous stage along on each shift.
            always_ff @(posedge clk) begin
                if (!rst_n)     stage[k] <= '0;
                else if (shift) stage[k] <= stage[k-1];
            end
        end
    end

    assign idx = IDX_W'(rd_sel - 1'b1);

    // Select the live input or a stored stage.
    always_comb begin
        if (rd_sel == '0)                   rd_data = din;
        else if (rd_sel <= SEL_W'(DEPTH))   rd_data = stage[idx];
        else                                rd_data = '0;
    end

    // R8: without a shift, the head stage keeps its value.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(stage[0]));
    // R2: a shift captures the presented sample.
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> stage[0] == $past(din));
endmodule

// File: rtl/pa_cal_reg.sv
// Calibration code register and tap computation for channel B.
// tap = clamp(NOM + signed(code) - CENTER, 0, MAXTAP).
// Reset loads CENTER, which gives a tap equal to NOM.
module pa_cal_reg #(
    parameter int CODE_W = 6,
    parameter int CENTER = 13,
    parameter int NOM    = 44,
    parameter int MAXTAP = 88,
    parameter int SEL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_data,
    output logic [SEL_W-1:0]  tap
);
    logic [CODE_W-1:0] cal_q;
    int                raw;

    // Hold the host-written code.
    always_ff @(posedge clk) begin
        if (!rst_n)     cal_q <= CODE_W'(CENTER);
        else if (wr_en) cal_q <= wr_data;
    end

    // Turn the signed code into a saturated tap index.
    always_comb begin
        raw = NOM - CENTER + int'($signed(cal_q));
        if (raw < 0)            tap = '0;
        else if (raw > MAXTAP)  tap = SEL_W'(MAXTAP);
        else                    tap = SEL_W'(raw);
        p_tap_range_r3: assert (int'(tap) <= MAXTAP);
    end

    // R6: reset restores the zero-shift code.
    p_reset_code_r6: assert property (@(posedge clk)
        !rst_n |=> cal_q == CODE_W'(CENTER));
    // R9: a write is registered at the edge where it is presented.
    p_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cal_q == $past(wr_data));
endmodule

// File: rtl/phase_align_delay.sv
// Two-channel phase-alignment delay.
// Channel A is delayed by NOM ticks. Channel B is delayed by a tap set by a
// signed calibration code centred on CENTER. Both lines advance only on
// accepted ticks (tick and in_valid). Outputs are registered on those ticks,
// so a code change always applies to whole samples.
module phase_align_delay
    import phase_align_pkg::*;
#(
    parameter int DW       = PA_SAMPLE_W,
    parameter int CODE_W   = PA_CODE_W,
    parameter int CENTER   = PA_CENTER,
    parameter int NOM      = PA_NOMINAL,
    parameter int MAXTAP   = 2 * PA_NOMINAL,
    parameter int TICK_DIV = PA_TICK_DIV
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_en,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] ch_a_in,
    input  logic signed [DW-1:0] ch_b_in,
    input  logic                 cal_we,
    input  logic [CODE_W-1:0]    cal_wdata,
    output logic                 tick_o,
    output logic                 out_valid,
    output logic signed [DW-1:0] ch_a_out,
    output logic signed [DW-1:0] ch_b_out
);
    localparam int SEL_W = $clog2(MAXTAP + 1);
    localparam logic [SEL_W-1:0] NOM_SEL = SEL_W'(NOM);
    localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(MAXTAP);

    logic                 tick;
    logic                 accept;
    logic [SEL_W-1:0]     tap_b;
    logic [SEL_W-1:0]     need;
    logic [SEL_W-1:0]     fill;
    logic signed [DW-1:0] a_tap, b_tap;

    pa_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .tick(tick)
    );

    pa_cal_reg #(
        .CODE_W(CODE_W), .CENTER(CENTER), .NOM(NOM),
        .MAXTAP(MAXTAP), .SEL_W(SEL_W)
    ) u_cal (
        .clk(clk), .rst_n(rst_n), .wr_en(cal_we), .wr_data(cal_wdata),
        .tap(tap_b)
    );

    assign accept = tick && in_valid;
    assign tick_o = tick;

    pa_delay_line #(.DW(DW), .DEPTH(MAXTAP), .SEL_W(SEL_W)) u_line_a (
        .clk(clk), .rst_n(rst_n), .shift(accept), .din(ch_a_in),
        .rd_sel(NOM_SEL), .rd_data(a_tap)
    );

    pa_delay_line #(.DW(DW), .DEPTH(MAXTAP), .SEL_W(SEL_W)) u_line_b (
        .clk(clk), .rst_n(rst_n), .shift(accept), .din(ch_b_in),
        .rd_sel(tap_b), .rd_data(b_tap)
    );

    // The longer of the two selected delays must be filled before output.
    assign need = (tap_b > NOM_SEL) ? tap_b : NOM_SEL;

    // Count accepted samples since reset, saturating at the line depth.
    always_ff @(posedge clk) begin
        if (!rst_n)                        fill <= '0;
        else if (accept && fill != MAX_SEL) fill <= fill + 1'b1;
    end

    // Register the aligned pair and its valid flag on accepted ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_a_out  <= '0;
            ch_b_out  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= accept && (fill >= need);
            if (accept) begin
                ch_a_out <= a_tap;
                ch_b_out <= b_tap;
            end
        end
    end

    // R10: outputs change only after an accepted tick.
    p_out_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(ch_a_out) && $stable(ch_b_out)));
    // R7: valid never appears without an accepted tick before it.
    p_valid_needs_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !out_valid);
endmodule

// File: tb/sim_phase_align_delay.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected pairs, the monitor pops them.
module sim_phase_align_delay;
    localparam int NOM   = 44;
    localparam int OFF_B = 32'h0040_0000;

    typedef struct {
        bit    v;
        int    a;
        int    b;
        int    tap;
        string tag;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               clk_en = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [23:0] ch_a_in = '0;
    logic signed [23:0] ch_b_in = '0;
    logic               cal_we = 1'b0;
    logic [5:0]         cal_wdata = '0;
    logic               tick_o;
    logic               out_valid;
    logic signed [23:0] ch_a_out, ch_b_out;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    int   n_acc = 0;
    int   code = 13;
    bit   started = 1'b0;
    bit   armed = 1'b0;
    int   prev_a = 0, prev_b = 0;

    phase_align_delay u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .in_valid(in_valid),
        .ch_a_in(ch_a_in), .ch_b_in(ch_b_in), .cal_we(cal_we),
        .cal_wdata(cal_wdata), .tick_o(tick_o), .out_valid(out_valid),
        .ch_a_out(ch_a_out), .ch_b_out(ch_b_out)
    );

    always #2.5 clk = ~clk;

    function automatic int tap_of(int c);
        int s, t;
        s = (c >= 32) ? c - 64 : c;
        t = NOM + s - 13;
        if (t < 0)  t = 0;
        if (t > 88) t = 88;
        return t;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        forever begin
            @(posedge clk); #1;
            if (tick_o) break;
        end
    endtask

    // Drive one tick slot; optionally write a code in the same clock.
    task automatic send(bit valid, string tag, bit wr = 1'b0, int wcode = 0);
        exp_t e;
        int t;
        wait_tick();
        in_valid = valid;
        ch_a_in  = 24'(n_acc + 1);
        ch_b_in  = 24'(n_acc + 1 + OFF_B);
        if (valid) begin
            t     = tap_of(code);
            e.v   = (n_acc >= ((t > NOM) ? t : NOM));
            e.a   = (n_acc >= NOM) ? n_acc + 1 - NOM : 0;
            e.b   = (n_acc >= t) ? n_acc + 1 - t + OFF_B : 0;
            e.tap = t;
            e.tag = tag;
            q.push_back(e);
            n_acc++;
        end
        if (wr) begin
            cal_we    = 1'b1;
            cal_wdata = 6'(wcode);
            code      = wcode;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        cal_we   = 1'b0;
    endtask

    task automatic write_cal(int c);
        @(posedge clk); #1;
        cal_we = 1'b1; cal_wdata = 6'(c); code = c;
        @(posedge clk); #1;
        cal_we = 1'b0;
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n; i++) send(1'b1, tag);
    endtask

    // Monitor: compare each accepted slot's result one clock later.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && started) begin
            if (armed) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R7 queue", 0, 1);
                end else begin
                    e = q.pop_front();
                    chk(out_valid == e.v, "R7 valid", int'(out_valid), int'(e.v));
                    chk(int'(ch_a_out) == e.a, "R2 chA", int'(ch_a_out), e.a);
                    chk(int'(ch_b_out) == e.b, {"R3 chB ", e.tag},
                        int'(ch_b_out), e.b);
                    if (e.v)
                        chk(int'(ch_a_out) - (int'(ch_b_out) - OFF_B) == e.tap - NOM,
                            {e.tag, " lag"},
                            int'(ch_a_out) - (int'(ch_b_out) - OFF_B), e.tap - NOM);
                end
            end else begin
                chk(out_valid == 1'b0, "R7 idle valid", int'(out_valid), 0);
                chk(int'(ch_a_out) == prev_a && int'(ch_b_out) == prev_b,
                    "R10 hold", int'(ch_a_out), prev_a);
            end
        end
        prev_a = int'(ch_a_out);
        prev_b = int'(ch_b_out);
        armed  = rst_n && in_valid && tick_o;
    end

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int gap;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 reset valid", int'(out_valid), 0);
        chk(ch_a_out == 0 && ch_b_out == 0, "R6 reset data", int'(ch_b_out), 0);
        started = 1'b1;

        // R1: spacing between ticks with the clock enable held high.
        wait_tick();
        gap = 0;
        do begin
            @(posedge clk); #1; gap++;
        end while (!tick_o && gap < 50);
        chk(gap == 8, "R1 tick period", gap, 8);

        run(100, "R4 centre");
        write_cal(6'h0B); run(20, "R4 advance");
        write_cal(6'h0F); run(20, "R4 delay");
        write_cal(6'h21); run(20, "R5 min");
        write_cal(6'h1F); run(30, "R5 max");
        write_cal(6'h20); run(10, "R5 clamp");
        write_cal(6'h0D); run(2, "R4 centre");

        // R9: a write in the same clock as an accepted tick.
        send(1'b1, "R9 same-clock", 1'b1, 6'h0F);
        run(3, "R9 after");

        // R8: ticks without valid samples.
        for (int i = 0; i < 3; i++) send(1'b0, "R8");
        run(5, "R8 resume");

        // R1: a disabled clock stops the ticks.
        @(posedge clk); #1 clk_en = 1'b0;
        for (int i = 0; i < 20; i++) begin
            chk(tick_o == 1'b0, "R1 disabled tick", int'(tick_o), 0);
            @(posedge clk); #1;
        end
        clk_en = 1'b1;
        run(3, "R1 resume");

        // R6: a mid-run reset restores the centre code and empty lines.
        @(posedge clk); #1 rst_n = 1'b0;
        n_acc = 0; code = 13;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(ch_a_out == 0 && ch_b_out == 0 && !out_valid, "R6 mid-run reset",
            int'(ch_a_out), 0);
        run(60, "R6 default code");

        repeat (4) @(posedge clk);
        chk(q.size() == 0, "R7 drained", q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule